// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming interface of an eight-line interrupt controller. Software reaches it through two byte ports picked by a single address bit. Port 0 takes command bytes and returns a status vector. Port 1 takes data bytes and returns the line mask. The block sorts every write into one of these kinds: a start-of-setup word, an operation command, a read-select command, or a data byte.

After a start-of-setup word, the data port receives an ordered series of setup bytes. The first is the vector base. The second, in cascade mode only, is the cascade word. The last, only if it was requested, is the mode word. The block holds the resulting configuration: trigger kind, single or cascade operation, vector base, cascade map or slave identity, and automatic end-of-interrupt. Once setup is complete, data-port writes load the line mask.

The block does not resolve priority and does not track in-service state. It receives the request and in-service vectors from outside, only so they can be read back. The end-of-interrupt commands it decodes are issued as one-cycle strobes for that neighbouring logic. The master or slave role is a static input.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the mask is 0x00, automatic end-of-interrupt is off, no end-of-interrupt strobe is active, and a port-0 read returns the request vector.
- R2: A port-0 write with bit 4 set starts setup. It clears the mask, sets the trigger output to bit 3 (1 = edge, 0 = level), and sets single mode when bit 1 is 1. The next port-1 write goes to the vector base, not to the mask.
- R3: The vector base stores the written byte with bits [2:0] forced to zero.
- R4: In single mode, setup ends after the vector base and the cascade configuration reads 0x00. The following port-1 write loads the mask.
- R5: In cascade mode, the port-1 write after the base is the cascade word. A master keeps all 8 bits. A slave keeps only bits [2:0], with the upper bits zero.
- R6: When bit 0 of the start word was 1, the port-1 write after the cascade word (or after the base in single mode) is the mode word. Its bit 1 sets automatic end-of-interrupt, and setup then ends.
- R7: A start word with bit 0 = 0 clears automatic end-of-interrupt, and setup ends without a mode word.
- R8: A port-1 write outside setup loads the 8-bit mask. A port-1 read returns the mask.
- R9: A port-0 write with bits [4:3] = 00 is an operation command, coded in bits [7:5]:
  - 001 gives a one-cycle strobe with the non-specific flag set and line 0.
  - 011 gives a one-cycle strobe with the non-specific flag clear and the line taken from bits [2:0].
  - Every other code gives no strobe and changes nothing.
- R10: A port-0 write with bits [4:3] = 01 is the read-select command. If its bit 1 is 1, bit 0 picks the request vector (1) or the in-service vector (0) for port-0 reads. If its bit 1 is 0, the selection is unchanged.
- R11: A start word received in the middle of setup restarts the sequence from the vector base, using the new start word's options.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Static role: 1 = master, 0 = slave |
| port_sel | input | 1 | Port select for reads and writes: 0 = command/status, 1 = data/mask |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write byte |
| req_vec | input | 8 | Request vector, for readback only |
| isr_vec | input | 8 | In-service vector, for readback only |
| rd_data | output | 8 | Read byte for the port picked by port_sel (combinational) |
| mask_o | output | 8 | Line mask |
| edge_trig | output | 1 | 1 = edge triggered, 0 = level |
| single_mode | output | 1 | 1 = single controller, 0 = cascade |
| vec_base | output | 8 | Vector base, bits [2:0] always zero |
| casc_cfg | output | 8 | Slave map (master) or slave identity (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| eoi_stb | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_nonspec | output | 1 | Strobe is non-specific |
| eoi_line | output | 3 | Line of a specific end-of-interrupt |

## Verification
A wrong setup step shows up on the very next data-port write. The byte lands in the wrong holder: the mask, the base, the cascade configuration or the mode flag. That wrong value is visible on the outputs in the following cycle. A stale read-select flag changes the port-0 read data at once, with no clock. A misdecoded operation code shows up as a strobe that is present, missing or wrongly flagged in the cycle right after the write.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_BASE = 2'd1,
      STEP_CASC = 2'd2,
      STEP_MODE = 2'd3
   } init_step_e;

   typedef struct packed {
      logic start;   // start-of-setup word on port 0
      logic opcmd;   // operation command on port 0
      logic rdsel;   // read-select command on port 0
      logic data;    // any write to port 1
   } wr_kind_t;

   localparam logic [2:0] OP_EOI_ANY  = 3'b001;
   localparam logic [2:0] OP_EOI_LINE = 3'b011;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
   import pic_cmd_pkg::*;
(
   input  logic       wr_en,
   input  logic       port_sel,
   input  logic [1:0] kind_bits,   // write byte bits [4:3]
   output wr_kind_t   kind
);
   always_comb begin
      kind       = '0;
      kind.data  = wr_en && port_sel;
      kind.start = wr_en && !port_sel && kind_bits[1];
      kind.opcmd = wr_en && !port_sel && (kind_bits == 2'b00);
      kind.rdsel = wr_en && !port_sel && (kind_bits == 2'b01);
   end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master,
   input  wr_kind_t          kind,
   input  logic [DATA_W-1:0] wr_data,
   output init_step_e        step,
   output logic              edge_trig,
   output logic              single_mode,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] casc_cfg,
   output logic              auto_eoi
);
   logic want_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step        <= STEP_IDLE;
         edge_trig   <= 1'b0;
         single_mode <= 1'b0;
         want_mode   <= 1'b0;
         vec_base    <= '0;
         casc_cfg    <= '0;
         auto_eoi    <= 1'b0;
      end else if (kind.start) begin
         edge_trig   <= wr_data[3];
         single_mode <= wr_data[1];
         want_mode   <= wr_data[0];
         if (!wr_data[0]) auto_eoi <= 1'b0;
         step        <= STEP_BASE;
      end else if (kind.data) begin
         unique case (step)
            STEP_BASE: begin
               vec_base <= {wr_data[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
               if (single_mode) begin
                  casc_cfg <= '0;
                  step     <= want_mode ? STEP_MODE : STEP_IDLE;
               end else begin
                  step     <= STEP_CASC;
               end
            end
            STEP_CASC: begin
               casc_cfg <= is_master ? wr_data
                                     : {{(DATA_W-LINE_W){1'b0}}, wr_data[LINE_W-1:0]};
               step     <= want_mode ? STEP_MODE : STEP_IDLE;
            end
            STEP_MODE: begin
               auto_eoi <= wr_data[1];
               step     <= STEP_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pic_op_unit.sv
module pic_op_unit
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_t          kind,
   input  logic              init_idle,
   input  logic              port_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] req_vec,
   input  logic [DATA_W-1:0] isr_vec,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] mask_o,
   output logic              eoi_stb,
   output logic              eoi_nonspec,
   output logic [LINE_W-1:0] eoi_line
);
   logic pick_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o      <= '0;
         pick_req    <= 1'b1;
         eoi_stb     <= 1'b0;
         eoi_nonspec <= 1'b0;
         eoi_line    <= '0;
      end else begin
         eoi_stb <= 1'b0;
         if (kind.start)                  mask_o <= '0;
         else if (kind.data && init_idle) mask_o <= wr_data;
         if (kind.rdsel && wr_data[1])    pick_req <= wr_data[0];
         if (kind.opcmd) begin
            if (wr_data[7:5] == OP_EOI_ANY) begin
               eoi_stb     <= 1'b1;
               eoi_nonspec <= 1'b1;
               eoi_line    <= '0;
            end else if (wr_data[7:5] == OP_EOI_LINE) begin
               eoi_stb     <= 1'b1;
               eoi_nonspec <= 1'b0;
               eoi_line    <= wr_data[LINE_W-1:0];
            end
         end
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_rd
      assign rd_data[b] = port_sel ? mask_o[b] : (pick_req ? req_vec[b] : isr_vec[b]);
   end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master,
   input  logic              port_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] req_vec,
   input  logic [DATA_W-1:0] isr_vec,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] mask_o,
   output logic              edge_trig,
   output logic              single_mode,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] casc_cfg,
   output logic              auto_eoi,
   output logic              eoi_stb,
   output logic              eoi_nonspec,
   output logic [$clog2(DATA_W)-1:0] eoi_line
);
   localparam int LINE_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("pic_cmd_seq: command byte layout needs DATA_W == 8");
   end

   wr_kind_t   kind;
   init_step_e init_step;
   logic       init_idle;

   pic_wr_decode u_dec (
      .wr_en     (wr_en),
      .port_sel  (port_sel),
      .kind_bits (wr_data[4:3]),
      .kind      (kind)
   );

   pic_init_fsm #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .is_master   (is_master),
      .kind        (kind),
      .wr_data     (wr_data),
      .step        (init_step),
      .edge_trig   (edge_trig),
      .single_mode (single_mode),
      .vec_base    (vec_base),
      .casc_cfg    (casc_cfg),
      .auto_eoi    (auto_eoi)
   );

   assign init_idle = (init_step == STEP_IDLE);

   pic_op_unit #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_op (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind        (kind),
      .init_idle   (init_idle),
      .port_sel    (port_sel),
      .wr_data     (wr_data),
      .req_vec     (req_vec),
      .isr_vec     (isr_vec),
      .rd_data     (rd_data),
      .mask_o      (mask_o),
      .eoi_stb     (eoi_stb),
      .eoi_nonspec (eoi_nonspec),
      .eoi_line    (eoi_line)
   );
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              is_master,
   input logic              port_sel,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] mask_o,
   input logic [DATA_W-1:0] vec_base,
   input logic [DATA_W-1:0] casc_cfg,
   input logic              auto_eoi,
   input logic              eoi_stb,
   input init_step_e        init_step,
   input logic              init_idle
);
   // R9: a strobe only follows a port-0 operation command
   assert_eoi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_stb |-> $past(wr_en && !port_sel && wr_data[4:3] == 2'b00));

   // R2: start word clears the mask and leaves the idle step
   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_sel && wr_data[4]) |=> (mask_o == '0 && !init_idle));

   // R3: base low bits are always zero
   assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_base[LINE_W-1:0] == '0);

   // R8: data write while idle lands in the mask
   assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && init_idle) |=> (mask_o == $past(wr_data)));

   // R7: start word without mode word clears automatic end-of-interrupt
   assert_no_mode_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_sel && wr_data[4] && !wr_data[0]) |=> !auto_eoi);

   // R5: a slave keeps only an identity in the cascade word
   assert_slave_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && init_step == STEP_CASC && !is_master)
      |=> casc_cfg[DATA_W-1:LINE_W] == '0);
endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .is_master (is_master),
   .port_sel  (port_sel),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .mask_o    (mask_o),
   .vec_base  (vec_base),
   .casc_cfg  (casc_cfg),
   .auto_eoi  (auto_eoi),
   .eoi_stb   (eoi_stb),
   .init_step (init_step),
   .init_idle (init_idle)
);

// File: tb/tb_pic_cmd_seq.sv
`timescale 1ns/1ps
module tb_pic_cmd_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 1'b1;
   logic       port_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] req_vec = 8'hA5;
   logic [7:0] isr_vec = 8'h3C;
   logic [7:0] rd_data, mask_o, vec_base, casc_cfg;
   logic       edge_trig, single_mode, auto_eoi, eoi_stb, eoi_nonspec;
   logic [2:0] eoi_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pic_cmd_seq dut (
      .clk(clk), .rst_n(rst_n), .is_master(is_master), .port_sel(port_sel),
      .wr_en(wr_en), .wr_data(wr_data), .req_vec(req_vec), .isr_vec(isr_vec),
      .rd_data(rd_data), .mask_o(mask_o), .edge_trig(edge_trig),
      .single_mode(single_mode), .vec_base(vec_base), .casc_cfg(casc_cfg),
      .auto_eoi(auto_eoi), .eoi_stb(eoi_stb), .eoi_nonspec(eoi_nonspec),
      .eoi_line(eoi_line)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one write; returns at the falling edge after the capturing edge
   task automatic wr(input logic p, input logic [7:0] d);
      @(negedge clk);
      port_sel = p; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic p, output logic [7:0] d);
      port_sel = p;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] r;
      rd(1'b0, r);
      check("R1 read req", r, 8'hA5);
      check("R1 mask", mask_o, 8'h00);
      check("R1 auto", {7'b0, auto_eoi}, 8'h00);
      check("R1 stb", {7'b0, eoi_stb}, 8'h00);
   endtask

   task automatic t_single();
      wr(1'b1, 8'hFF);
      check("R8 mask idle", mask_o, 8'hFF);
      wr(1'b0, 8'h1A);
      check("R2 mask clr", mask_o, 8'h00);
      check("R2 edge", {7'b0, edge_trig}, 8'h01);
      check("R2 single", {7'b0, single_mode}, 8'h01);
      wr(1'b1, 8'h47);
      check("R3 base", vec_base, 8'h40);
      check("R2 base not mask", mask_o, 8'h00);
      check("R4 casc zero", casc_cfg, 8'h00);
      wr(1'b1, 8'h81);
      check("R4 mask after", mask_o, 8'h81);
      check("R4 base kept", vec_base, 8'h40);
   endtask

   task automatic t_master_mode();
      is_master = 1'b1;
      wr(1'b0, 8'h11);
      check("R2 level", {7'b0, edge_trig}, 8'h00);
      check("R2 cascade", {7'b0, single_mode}, 8'h00);
      wr(1'b1, 8'h20);
      check("R3 base", vec_base, 8'h20);
      wr(1'b1, 8'h5A);
      check("R5 master map", casc_cfg, 8'h5A);
      wr(1'b1, 8'h03);
      check("R6 auto set", {7'b0, auto_eoi}, 8'h01);
      check("R6 mask untouched", mask_o, 8'h00);
      wr(1'b1, 8'h0F);
      check("R6 idle mask", mask_o, 8'h0F);
   endtask

   task automatic t_no_mode();
      wr(1'b0, 8'h10);
      check("R7 auto clr", {7'b0, auto_eoi}, 8'h00);
      wr(1'b1, 8'h08);
      wr(1'b1, 8'hFF);
      check("R5 casc", casc_cfg, 8'hFF);
      wr(1'b1, 8'h11);
      check("R7 ends mask", mask_o, 8'h11);
      check("R7 auto stays", {7'b0, auto_eoi}, 8'h00);
   endtask

   task automatic t_slave();
      is_master = 1'b0;
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h70);
      wr(1'b1, 8'hFE);
      check("R5 slave id", casc_cfg, 8'h06);
      wr(1'b1, 8'h00);
      check("R6 auto off", {7'b0, auto_eoi}, 8'h00);
      wr(1'b1, 8'h3C);
      check("R8 mask", mask_o, 8'h3C);
      is_master = 1'b1;
   endtask

   task automatic t_opcmd();
      wr(1'b0, 8'h20);
      check("R9 ns stb", {7'b0, eoi_stb}, 8'h01);
      check("R9 ns flag", {7'b0, eoi_nonspec}, 8'h01);
      @(negedge clk);
      check("R9 one cycle", {7'b0, eoi_stb}, 8'h00);
      wr(1'b0, 8'h65);
      check("R9 sp stb", {7'b0, eoi_stb}, 8'h01);
      check("R9 sp flag", {7'b0, eoi_nonspec}, 8'h00);
      check("R9 sp line", {5'b0, eoi_line}, 8'h05);
      wr(1'b0, 8'h40);
      check("R9 noop", {7'b0, eoi_stb}, 8'h00);
      wr(1'b0, 8'hE3);
      check("R9 other", {7'b0, eoi_stb}, 8'h00);
      check("R9 mask kept", mask_o, 8'h3C);
   endtask

   task automatic t_rdsel();
      logic [7:0] r;
      wr(1'b0, 8'h0A);
      rd(1'b0, r); check("R10 isr", r, 8'h3C);
      wr(1'b0, 8'h09);
      rd(1'b0, r); check("R10 no change", r, 8'h3C);
      wr(1'b0, 8'h0B);
      rd(1'b0, r); check("R10 req", r, 8'hA5);
      rd(1'b1, r); check("R8 read mask", r, 8'h3C);
   endtask

   task automatic t_restart();
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h30);
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h48);
      check("R11 base", vec_base, 8'h48);
      check("R11 single", {7'b0, single_mode}, 8'h01);
      wr(1'b1, 8'h02);
      check("R11 mode word", {7'b0, auto_eoi}, 8'h01);
      check("R11 mask", mask_o, 8'h00);
      wr(1'b1, 8'h77);
      check("R11 idle", mask_o, 8'h77);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_master_mode();
      t_no_mode();
      t_slave();
      t_opcmd();
      t_rdsel();
      t_restart();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule